// File: doc/BRIEF.md
# Parallel Flash Bus Mode Decoder

This block sits between the pins of a parallel NOR-style flash device and its internal logic. Each cycle it reads the active-low reset, a 3-bit active-low chip-enable group, output enable and write enable, and classifies the bus into one mode. The modes are reset/power-down, standby, output disable, read, write, or an illegal read/write conflict. From that mode it controls per-bit tri-state enables on the 16-bit data bus. A byte-mode pin limits the bus to the low byte.

In read mode the outgoing data comes from one of four sources: the array, the identifier codes, the query table or the status register. A status read taken while the internal write engine is running drives only bit 7. Write cycles are captured on the rising edge of write enable, which is detected on the internal clock. A captured write goes to the command side as one pulse, and only when the program-enable voltage flag was valid. An open-drain ready/busy pin is pulled low only while the write engine is actively running.

Top module: `flash_bus_front`

## Requirements
- R1: While rst_ni is low, data_oe_o is all zeros, sts_low_o is 0, mode_o is 0, cmd_valid_o is 0 and proto_err_o is cleared, whatever the other inputs are.
- R2: The device is enabled for every ce_ni value except 3'b111. When it is not enabled, mode_o is 1 (standby) and data_oe_o is zero.
- R3: When the device is enabled with oe_ni=1 and we_ni=1, mode_o is 2 (output disable) and data_oe_o is zero. In write mode (oe_ni=1, we_ni=0) mode_o is 4 and data_oe_o is zero.
- R4: When the device is enabled with oe_ni=0 and we_ni=1, mode_o is 3 (read). data_o carries the source selected by src_sel_i: 0 array_data_i, 1 id_data_i, 2 query_data_i, 3 the status byte zero-extended to 16 bits.
- R5: A status read (src_sel_i=3) while wsm_state_i=1 (running) sets data_oe_o to 16'h0080, and data_o carries only status bit 7. In the other engine states the whole status value is driven on the active lanes.
- R6: In read mode with byte_i=0, data_oe_o is 16'h00FF and data_o[15:8] is 0. With byte_i=1, data_oe_o is 16'hFFFF, except in the case covered by R5.
- R7: A write is held with we_ni low for at least one clock edge and then released. One clock edge after we_ni rises, cmd_valid_o is high for exactly one cycle. cmd_data_o then holds the data sampled at the last write-mode edge, with bits 15:8 forced to 0 if byte_i was low.
- R8: A write whose last sampled edge had vpen_ok_i=0 produces no cmd_valid_o pulse.
- R9: sts_low_o is 1 exactly when rst_ni is high and wsm_state_i is 1 (running). It is 0 when idle (0), in erase suspend (2) and in program suspend (3).
- R10: When the device is enabled with oe_ni=0 and we_ni=0, mode_o is 5, data_oe_o is zero, and releasing that state gives no cmd_valid_o pulse. proto_err_o is set at the next clock edge and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low reset/power-down pin, asynchronous |
| ce_ni | input | 3 | Active-low chip-enable group |
| oe_ni | input | 1 | Active-low output enable |
| we_ni | input | 1 | Active-low write enable |
| byte_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| vpen_ok_i | input | 1 | Program-enable voltage is at the valid level |
| src_sel_i | input | 2 | Read source select |
| wsm_state_i | input | 2 | Write engine state: 0 idle, 1 running, 2 erase suspend, 3 program suspend |
| array_data_i | input | 16 | Array read data |
| id_data_i | input | 16 | Identifier read data |
| query_data_i | input | 16 | Query table read data |
| status_i | input | 8 | Status register |
| data_i | input | 16 | Data bus input |
| data_o | output | 16 | Data bus output value |
| data_oe_o | output | 16 | Per-bit output enable of the data bus |
| sts_low_o | output | 1 | Open-drain ready/busy: 1 pulls the pin low |
| mode_o | output | 3 | Decoded bus mode |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_data_o | output | 16 | Captured write data |
| proto_err_o | output | 1 | Sticky read/write conflict flag |

## Verification
The hardest case to reach is the way write release interacts with the clock. The command pulse depends on a write-mode sample at one edge followed by a released write enable at the next. The stimulus therefore holds write enable low across several edges before releasing it on a falling clock edge. The bench then counts pulses over the following cycles, with the voltage flag valid and with it dropped. A conflict is reached by bringing output enable low inside a write window. Releasing it must leave no pulse, and the sticky flag must survive until the next reset. A full sweep covers every chip-enable value, control pair, byte mode, source and engine state.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
  typedef enum logic [2:0] {
    MODE_RESET    = 3'd0,
    MODE_STANDBY  = 3'd1,
    MODE_OUT_DIS  = 3'd2,
    MODE_READ     = 3'd3,
    MODE_WRITE    = 3'd4,
    MODE_CONFLICT = 3'd5
  } bus_mode_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_IDENT  = 2'd1,
    SRC_QUERY  = 2'd2,
    SRC_STATUS = 2'd3
  } rd_src_e;

  typedef enum logic [1:0] {
    WSM_IDLE     = 2'd0,
    WSM_RUN      = 2'd1,
    WSM_ERS_SUSP = 2'd2,
    WSM_PGM_SUSP = 2'd3
  } wsm_state_e;
endpackage

// File: rtl/fbf_mode_decode.sv
module fbf_mode_decode
  import flash_bus_pkg::*;
#(
  parameter int NUM_CE = 3,
  localparam int CE_COMBOS = 1 << NUM_CE,
  parameter logic [CE_COMBOS-1:0] CE_EN_MAP = {1'b0, {(CE_COMBOS-1){1'b1}}}
) (
  input  logic              rst_ni,
  input  logic [NUM_CE-1:0] ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  output bus_mode_e         mode_o
);
  logic [CE_COMBOS-1:0] combo_hit;
  logic                 chip_en;

  // one-hot match of the current chip-enable pattern against the map
  for (genvar c = 0; c < CE_COMBOS; c++) begin : g_combo
    assign combo_hit[c] = (ce_ni == NUM_CE'(c)) && CE_EN_MAP[c];
  end
  assign chip_en = |combo_hit;

  always_comb begin
    if (!rst_ni)       mode_o = MODE_RESET;
    else if (!chip_en) mode_o = MODE_STANDBY;
    else begin
      unique case ({oe_ni, we_ni})
        2'b11:   mode_o = MODE_OUT_DIS;
        2'b01:   mode_o = MODE_READ;
        2'b10:   mode_o = MODE_WRITE;
        default: mode_o = MODE_CONFLICT;
      endcase
    end
  end
endmodule

// File: rtl/fbf_read_path.sv
module fbf_read_path
  import flash_bus_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 8,
  parameter int BUSY_BIT = 7,
  localparam int LANES = DW / 8
) (
  input  bus_mode_e        mode_i,
  input  logic             byte_i,
  input  rd_src_e          src_i,
  input  wsm_state_e       wsm_i,
  input  logic [DW-1:0]    array_i,
  input  logic [DW-1:0]    ident_i,
  input  logic [DW-1:0]    query_i,
  input  logic [SW-1:0]    status_i,
  output logic [DW-1:0]    data_o,
  output logic [DW-1:0]    oe_o
);
  logic [DW-1:0]    src_val;
  logic [DW-1:0]    lane_mask;
  logic [LANES-1:0] lane_on;
  logic             reading;
  logic             busy_stat;

  assign reading   = (mode_i == MODE_READ);
  assign busy_stat = (src_i == SRC_STATUS) && (wsm_i == WSM_RUN);

  // lane 0 always present; upper lanes only in word mode
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_low
      assign lane_on[l] = 1'b1;
    end else begin : g_high
      assign lane_on[l] = byte_i;
    end
    assign lane_mask[l*8 +: 8] = {8{lane_on[l]}};
  end

  always_comb begin
    unique case (src_i)
      SRC_ARRAY: src_val = array_i;
      SRC_IDENT: src_val = ident_i;
      SRC_QUERY: src_val = query_i;
      default:   src_val = {{(DW-SW){1'b0}}, status_i};
    endcase
  end

  always_comb begin
    oe_o = '0;
    if (reading) begin
      if (busy_stat) oe_o[BUSY_BIT] = 1'b1;
      else           oe_o = lane_mask;
    end
  end

  assign data_o = src_val & oe_o;
endmodule

// File: rtl/fbf_cmd_capture.sv
module fbf_cmd_capture
  import flash_bus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_mode_e     mode_i,
  input  logic          we_ni,
  input  logic          byte_i,
  input  logic          vpen_ok_i,
  input  logic [DW-1:0] data_i,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_data_o,
  output logic          proto_err_o
);
  logic          wr_q;
  logic          vpen_q;
  logic [DW-1:0] data_q;
  logic          release_evt;

  // write was seen at the previous edge and write enable is now high
  assign release_evt = wr_q && we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      vpen_q <= 1'b0;
      data_q <= '0;
    end else begin
      wr_q <= (mode_i == MODE_WRITE);
      if (mode_i == MODE_WRITE) begin
        vpen_q <= vpen_ok_i;
        data_q <= byte_i ? data_i : {{(DW-8){1'b0}}, data_i[7:0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_data_o  <= '0;
    end else begin
      cmd_valid_o <= release_evt && vpen_q;
      if (release_evt) cmd_data_o <= data_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        proto_err_o <= 1'b0;
    else if (mode_i == MODE_CONFLICT)   proto_err_o <= 1'b1;
  end
endmodule

// File: rtl/fbf_ready_pin.sv
module fbf_ready_pin
  import flash_bus_pkg::*;
(
  input  logic       rst_ni,
  input  wsm_state_e wsm_i,
  output logic       pull_low_o
);
  // suspend states and idle release the pin
  assign pull_low_o = rst_ni && (wsm_i == WSM_RUN);
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_bus_pkg::*;
#(
  parameter int NUM_CE = 3,
  parameter int DW = 16,
  parameter int SW = 8,
  localparam int CE_COMBOS = 1 << NUM_CE,
  parameter logic [CE_COMBOS-1:0] CE_EN_MAP = {1'b0, {(CE_COMBOS-1){1'b1}}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CE-1:0] ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              byte_i,
  input  logic              vpen_ok_i,
  input  logic [1:0]        src_sel_i,
  input  logic [1:0]        wsm_state_i,
  input  logic [DW-1:0]     array_data_i,
  input  logic [DW-1:0]     id_data_i,
  input  logic [DW-1:0]     query_data_i,
  input  logic [SW-1:0]     status_i,
  input  logic [DW-1:0]     data_i,
  output logic [DW-1:0]     data_o,
  output logic [DW-1:0]     data_oe_o,
  output logic              sts_low_o,
  output logic [2:0]        mode_o,
  output logic              cmd_valid_o,
  output logic [DW-1:0]     cmd_data_o,
  output logic              proto_err_o
);
  bus_mode_e  mode;
  rd_src_e    src;
  wsm_state_e wsm;

  assign src    = rd_src_e'(src_sel_i);
  assign wsm    = wsm_state_e'(wsm_state_i);
  assign mode_o = mode;

  fbf_mode_decode #(
    .NUM_CE   (NUM_CE),
    .CE_EN_MAP(CE_EN_MAP)
  ) i_decode (
    .rst_ni(rst_ni),
    .ce_ni (ce_ni),
    .oe_ni (oe_ni),
    .we_ni (we_ni),
    .mode_o(mode)
  );

  fbf_read_path #(
    .DW(DW),
    .SW(SW)
  ) i_read (
    .mode_i  (mode),
    .byte_i  (byte_i),
    .src_i   (src),
    .wsm_i   (wsm),
    .array_i (array_data_i),
    .ident_i (id_data_i),
    .query_i (query_data_i),
    .status_i(status_i),
    .data_o  (data_o),
    .oe_o    (data_oe_o)
  );

  fbf_cmd_capture #(
    .DW(DW)
  ) i_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .we_ni      (we_ni),
    .byte_i     (byte_i),
    .vpen_ok_i  (vpen_ok_i),
    .data_i     (data_i),
    .cmd_valid_o(cmd_valid_o),
    .cmd_data_o (cmd_data_o),
    .proto_err_o(proto_err_o)
  );

  fbf_ready_pin i_ready (
    .rst_ni    (rst_ni),
    .wsm_i     (wsm),
    .pull_low_o(sts_low_o)
  );
endmodule

// File: rtl/flash_bus_front_chk.sv
module flash_bus_front_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        oe_ni,
  input logic        we_ni,
  input logic        byte_i,
  input logic [1:0]  src_sel_i,
  input logic [1:0]  wsm_state_i,
  input logic [15:0] data_oe_o,
  input logic        sts_low_o,
  input logic [2:0]  mode_o,
  input logic        cmd_valid_o,
  input logic        proto_err_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_float_r1: assert (data_oe_o == '0 && !sts_low_o && !cmd_valid_o && !proto_err_o)
        else $error("reset float");
    end
  end

  p_quiet_unless_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'd3) |-> (data_oe_o == '0));

  p_busy_status_bit7_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && src_sel_i == 2'd3 && wsm_state_i == 2'd1) |-> (data_oe_o == 16'h0080));

  p_byte_lanes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_i |-> (data_oe_o[15:8] == 8'h00));

  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_pulse_after_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> we_ni);

  p_ready_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_low_o == (wsm_state_i == 2'd1));

  p_conflict_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && !we_ni) |-> (data_oe_o == '0));

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o);
endmodule

bind flash_bus_front flash_bus_front_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .oe_ni      (oe_ni),
  .we_ni      (we_ni),
  .byte_i     (byte_i),
  .src_sel_i  (src_sel_i),
  .wsm_state_i(wsm_state_i),
  .data_oe_o  (data_oe_o),
  .sts_low_o  (sts_low_o),
  .mode_o     (mode_o),
  .cmd_valid_o(cmd_valid_o),
  .proto_err_o(proto_err_o)
);

// File: tb/test_flash_bus_front.sv
module test_flash_bus_front;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  ce_ni = 3'b111;
  logic        oe_ni = 1'b1;
  logic        we_ni = 1'b1;
  logic        byte_i = 1'b1;
  logic        vpen_ok_i = 1'b0;
  logic [1:0]  src_sel_i = 2'd0;
  logic [1:0]  wsm_state_i = 2'd0;
  logic [15:0] array_data_i = 16'hA55A;
  logic [15:0] id_data_i = 16'h0089;
  logic [15:0] query_data_i = 16'h5152;
  logic [7:0]  status_i = 8'hC5;
  logic [15:0] data_i = 16'h0000;
  logic [15:0] data_o, data_oe_o, cmd_data_o;
  logic        sts_low_o, cmd_valid_o, proto_err_o;
  logic [2:0]  mode_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  flash_bus_front i_flash_bus_front (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .byte_i(byte_i), .vpen_ok_i(vpen_ok_i), .src_sel_i(src_sel_i),
    .wsm_state_i(wsm_state_i), .array_data_i(array_data_i), .id_data_i(id_data_i),
    .query_data_i(query_data_i), .status_i(status_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .sts_low_o(sts_low_o), .mode_o(mode_o),
    .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .proto_err_o(proto_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // write cycle: we low across edges, released on a falling edge
  task automatic do_write(input logic [15:0] d, input logic vp, input logic bm,
                          output int pulses, output logic [15:0] got);
    @(negedge clk_i);
    ce_ni = 3'b010; oe_ni = 1'b1; we_ni = 1'b0; data_i = d; vpen_ok_i = vp; byte_i = bm;
    repeat (3) @(negedge clk_i);
    we_ni = 1'b1;
    pulses = 0;
    got = 16'h0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk_i); #2;
      if (cmd_valid_o) begin pulses++; got = cmd_data_o; end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int pulses;
    logic [15:0] got;
    // R1: reset state with active read controls and a running engine
    ce_ni = 3'b000; oe_ni = 1'b0; we_ni = 1'b1; wsm_state_i = 2'd1;
    repeat (2) @(negedge clk_i);
    chk("R1 oe", data_oe_o, 0);
    chk("R1 sts", sts_low_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 err", proto_err_o, 0);
    chk("R1 cmd", cmd_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // full combinational sweep (R2..R6, R9, R10)
    for (int ce = 0; ce < 8; ce++)
      for (int ow = 0; ow < 4; ow++)
        for (int bm = 0; bm < 2; bm++)
          for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
              logic en;
              logic [2:0] em;
              logic [15:0] lane, val, eoe;
              ce_ni = 3'(ce); oe_ni = ow[1]; we_ni = ow[0]; byte_i = bm[0];
              src_sel_i = 2'(s); wsm_state_i = 2'(w);
              #1;
              en = (ce != 7);
              if (!en) em = 3'd1;
              else case (ow)
                3: em = 3'd2;
                1: em = 3'd3;
                2: em = 3'd4;
                default: em = 3'd5;
              endcase
              lane = bm ? 16'hFFFF : 16'h00FF;
              case (s)
                0: val = array_data_i;
                1: val = id_data_i;
                2: val = query_data_i;
                default: val = {8'h00, status_i};
              endcase
              if (em != 3'd3) eoe = 16'h0;
              else if (s == 3 && w == 1) eoe = 16'h0080;
              else eoe = lane;
              chk(!en ? "R2 mode" : (ow == 0 ? "R10 mode" : "R4 mode"), mode_o, em);
              chk(em == 3'd3 ? (s == 3 && w == 1 ? "R5 oe" : "R6 oe") : "R3 oe", data_oe_o, eoe);
              chk(em == 3'd3 ? "R4 data" : "R3 data", data_o, val & eoe);
              chk("R9 sts", sts_low_o, (w == 1));
              #1;
            end
    chk("R10 sticky err", proto_err_o, 1);

    // R1: reset clears sticky error
    @(negedge clk_i);
    ce_ni = 3'b111; oe_ni = 1'b1; we_ni = 1'b1; wsm_state_i = 2'd0;
    rst_ni = 1'b0; #1;
    chk("R1 err clear", proto_err_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    // R7: word and byte writes with valid voltage
    do_write(16'h3C70, 1'b1, 1'b1, pulses, got);
    chk("R7 pulses", pulses, 1);
    chk("R7 data", got, 16'h3C70);
    do_write(16'hBEEF, 1'b1, 1'b0, pulses, got);
    chk("R7 byte pulses", pulses, 1);
    chk("R7 byte data", got, 16'h00EF);
    // R8: lockout level
    do_write(16'h1234, 1'b0, 1'b1, pulses, got);
    chk("R8 no pulse", pulses, 0);
    chk("R10 err clean", proto_err_o, 0);

    // R10: conflict inside a write window
    @(negedge clk_i);
    ce_ni = 3'b000; vpen_ok_i = 1'b1; data_i = 16'h00D0; we_ni = 1'b0; oe_ni = 1'b1;
    @(negedge clk_i); oe_ni = 1'b0;
    @(negedge clk_i); #1;
    chk("R10 conflict oe", data_oe_o, 0);
    chk("R10 err set", proto_err_o, 1);
    we_ni = 1'b1; oe_ni = 1'b1;
    pulses = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_i); #2;
      if (cmd_valid_o) pulses++;
    end
    chk("R10 no pulse", pulses, 0);
    chk("R10 err held", proto_err_o, 1);

    done = 1;
    finish_run();
  end
endmodule